// File: doc/BRIEF.md
# Unlock-Sequenced Configuration Loader

This block guards the loading of a fixed-size firmware configuration image behind a byte-wide register bus. Software first writes a three-value key to a dedicated key register. The key is accepted only while an external ready condition is true, and the three writes must follow each other with no other bus access in between. A correct key opens a load window. Each write to the data register then counts one configuration byte, until the full image size has been reached.

The running byte count can be read back as a 13-bit value split over two read-only registers. A status register shows the ready input, whether a load is open, and whether the image has been fully received. The byte values themselves are not stored or checked here. A downstream consumer takes them directly from the bus.

Top module: `cfgld_loader`

## Requirements
- R1: After reset, the byte count is 0, the load window is closed (`unlocked_o`=0) and the complete flag is clear (`done_o`=0).
- R2: Three writes to the key register (address 0x74), carrying 0x51, then 0x52, then 0x53, open the load window on the clock edge of the third write.
- R3: Any read, at any address, or any write to an address other than 0x74, made between key writes abandons the key in progress. Idle bus cycles do not abandon it.
- R4: A key write made while `ready_i` is 0 is not honoured and returns the key detector to its start state.
- R5: A wrong key value at any step returns the detector to its start state. If that wrong value is 0x51, it counts as the first step of a new attempt, so the writes 0x51, 0x51, 0x52, 0x53 open the window.
- R6: While the window is open, each write to the data register (default address 0x75) raises the byte count by exactly one. While the window is closed, data writes leave the count unchanged.
- R7: When the count reaches the image size (7600 bytes), the window closes, `done_o` goes to 1, and further data writes leave the count at 7600.
- R8: A new successful key clears the count to 0, clears `done_o` and reopens the window.
- R9: A read of 0x72 returns count bits 7:0. A read of 0x73 returns count bits 12:8 in bits 4:0, with bits 7:5 as 0. A read of 0x71 returns {5'b0, done, unlocked, ready}. Any other address, and any cycle without a read strobe, returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ready_i | input | 1 | External condition that permits the key to be accepted |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as the read strobe |
| unlocked_o | output | 1 | Load window open |
| done_o | output | 1 | Full image received |

## Verification
Each key position is swept over all 256 byte values while the other two positions hold correct values. This separates an exact match at every step from a detector that looks at only some bits or only some steps. Separate patterns place a read, a foreign write, a data write, or a low ready input inside a key. These show that an abort depends on the kind of access and not on time passing. The load is driven through the whole 7600-byte image, and the split count is compared after every byte. This catches carry errors across the 8-bit boundary, an early or late saturation point, and bytes counted after completion.

// File: rtl/cfgld_pkg.sv
// Package: shared constants and types of the configuration loader.
// Assumes a byte-wide register bus.
package cfgld_pkg;
    localparam int BUS_DW = 8;

    // Key values, in the order they must be written.
    localparam logic [BUS_DW-1:0] KEY_STEP_A = 8'h51;
    localparam logic [BUS_DW-1:0] KEY_STEP_B = 8'h52;
    localparam logic [BUS_DW-1:0] KEY_STEP_C = 8'h53;

    // Progress of the key detector.
    typedef enum logic [1:0] {
        KEY_IDLE  = 2'd0,
        KEY_HAVE1 = 2'd1,
        KEY_HAVE2 = 2'd2
    } key_state_t;
endpackage

// File: rtl/cfgld_key_detect.sv
// Module: cfgld_key_detect
// Tracks the three-write unlock key on the register bus and pulses key_hit_o
// on the cycle of a correct third write. Assumes at most one access per cycle;
// any read, or a write to another address, abandons a key in progress.
module cfgld_key_detect
    import cfgld_pkg::*;
#(
    parameter int                  ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]   KEY_ADDR = 8'h74
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready_i,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [BUS_DW-1:0] wdata,
    output logic              key_hit_o
);
    key_state_t state, state_nxt;
    logic       key_wr;
    logic       foreign_acc;

    assign key_wr      = wr && (addr == KEY_ADDR);
    assign foreign_acc = rd || (wr && (addr != KEY_ADDR));

    // Next-state and hit decode of the key sequence.
    always_comb begin
        state_nxt = state;
        key_hit_o = 1'b0;
        if (foreign_acc) begin
            state_nxt = KEY_IDLE;
        end else if (key_wr) begin
            if (!ready_i) begin
                state_nxt = KEY_IDLE;
            end else begin
                case (state)
                    KEY_IDLE:  state_nxt = (wdata == KEY_STEP_A) ? KEY_HAVE1 : KEY_IDLE;
                    KEY_HAVE1: begin
                        if (wdata == KEY_STEP_B)      state_nxt = KEY_HAVE2;
                        else if (wdata == KEY_STEP_A) state_nxt = KEY_HAVE1;
                        else                          state_nxt = KEY_IDLE;
                    end
                    KEY_HAVE2: begin
                        key_hit_o = (wdata == KEY_STEP_C);
                        state_nxt = (wdata == KEY_STEP_A) ? KEY_HAVE1 : KEY_IDLE;
                    end
                    default:   state_nxt = KEY_IDLE;
                endcase
            end
        end
    end

    // State register of the key detector.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= KEY_IDLE;
        else        state <= state_nxt;
    end

    // R3: an interrupting access leaves the detector idle on the next cycle.
    assert_abort_on_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        foreign_acc |=> (state == KEY_IDLE));

    // R4: a hit only happens while ready is high, from the final step.
    assert_hit_needs_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit_o |-> (ready_i && state == KEY_HAVE2 && key_wr));

    // R5: a first key value while not at the last step always leads to step one.
    assert_restart_on_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && ready_i && !rd && wdata == KEY_STEP_A) |=> (state == KEY_HAVE1));
endmodule

// File: rtl/cfgld_byte_counter.sv
// Module: cfgld_byte_counter
// Holds the load window, the received-byte count and the complete flag.
// Assumes key_hit and data_wr come from the same bus cycle and that a key hit
// wins over a data write (they cannot coincide on a one-access bus).
module cfgld_byte_counter #(
    parameter int IMAGE_BYTES = 7600,
    parameter int CNT_W       = $clog2(IMAGE_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_hit,
    input  logic             data_wr,
    output logic [CNT_W-1:0] count_o,
    output logic             unlocked_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IMAGE_BYTES);

    logic [CNT_W-1:0] count_inc;
    assign count_inc = count_o + 1'b1;

    // Window, count and completion update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o    <= '0;
            unlocked_o <= 1'b0;
            done_o     <= 1'b0;
        end else if (key_hit) begin
            count_o    <= '0;
            unlocked_o <= 1'b1;
            done_o     <= 1'b0;
        end else if (data_wr && unlocked_o) begin
            count_o <= count_inc;
            if (count_inc == LAST) begin
                unlocked_o <= 1'b0;
                done_o     <= 1'b1;
            end
        end
    end

    // R7: the count never passes the image size.
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= LAST);

    // R7: window and completion are never both set.
    assert_done_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && unlocked_o));

    // R6: a closed window without a key keeps the count still.
    assert_locked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked_o && !key_hit) |=> $stable(count_o));

    // R6: outside a key hit the count moves by at most one per cycle.
    assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !key_hit |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));

    // R8: a key hit leaves an empty, open window.
    assert_key_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit |=> (count_o == '0 && unlocked_o && !done_o));
endmodule

// File: rtl/cfgld_read_mux.sv
// Module: cfgld_read_mux
// Returns status or count bytes on a read strobe. Assumes the count needs no
// more than 16 bits; unused high bits read as zero.
module cfgld_read_mux
    import cfgld_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                CNT_W    = 13,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h71,
    parameter logic [ADDR_W-1:0] CLO_ADDR  = 8'h72,
    parameter logic [ADDR_W-1:0] CHI_ADDR  = 8'h73
) (
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  count,
    input  logic              ready,
    input  logic              unlocked,
    input  logic              done,
    output logic [BUS_DW-1:0] rdata
);
    logic [2*BUS_DW-1:0] count_wide;
    assign count_wide = (2*BUS_DW)'(count);

    // Address decode of the readable registers.
    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr == STAT_ADDR)     rdata = {5'b0, done, unlocked, ready};
            else if (addr == CLO_ADDR) rdata = count_wide[BUS_DW-1:0];
            else if (addr == CHI_ADDR) rdata = count_wide[2*BUS_DW-1:BUS_DW];
        end
    end

    // R9: no read strobe means a quiet data bus.
    always_comb begin
        assert_quiet_idle_R9: assert (rd || rdata == '0);
    end
endmodule

// File: rtl/cfgld_loader.sv
// Module: cfgld_loader (top)
// Unlock-guarded configuration byte loader on a byte-wide register bus.
// Assumes one access (read or write) per cycle and that image bytes are
// consumed elsewhere directly from the bus.
module cfgld_loader
    import cfgld_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                IMAGE_BYTES = 7600,
    parameter logic [ADDR_W-1:0] KEY_ADDR    = 8'h74,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = 8'h75,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = 8'h71,
    parameter logic [ADDR_W-1:0] CLO_ADDR    = 8'h72,
    parameter logic [ADDR_W-1:0] CHI_ADDR    = 8'h73
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              unlocked_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(IMAGE_BYTES + 1);

    logic             key_hit;
    logic             data_wr;
    logic [CNT_W-1:0] count;

    assign data_wr = bus_wr && (bus_addr == DATA_ADDR);

    cfgld_key_detect #(
        .ADDR_W   (ADDR_W),
        .KEY_ADDR (KEY_ADDR)
    ) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready_i   (ready_i),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .wdata     (bus_wdata),
        .key_hit_o (key_hit)
    );

    cfgld_byte_counter #(
        .IMAGE_BYTES (IMAGE_BYTES),
        .CNT_W       (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_hit    (key_hit),
        .data_wr    (data_wr),
        .count_o    (count),
        .unlocked_o (unlocked_o),
        .done_o     (done_o)
    );

    cfgld_read_mux #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .STAT_ADDR (STAT_ADDR),
        .CLO_ADDR  (CLO_ADDR),
        .CHI_ADDR  (CHI_ADDR)
    ) u_rd (
        .rd       (bus_rd),
        .addr     (bus_addr),
        .count    (count),
        .ready    (ready_i),
        .unlocked (unlocked_o),
        .done     (done_o),
        .rdata    (bus_rdata)
    );

    // R1: the cycle after reset shows an empty, closed loader.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!unlocked_o && !done_o && count == '0));

    // R2: the window opens only following a correct third key write.
    assert_open_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked_o) |-> $past(key_hit));
endmodule

// File: tb/test_cfgld_loader.sv
// Bench for cfgld_loader: key-value sweeps, abort patterns and a full image load.
module test_cfgld_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ready_i = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       unlocked_o;
    logic       done_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    localparam logic [7:0] A_KEY  = 8'h74;
    localparam logic [7:0] A_DATA = 8'h75;
    localparam logic [7:0] A_STAT = 8'h71;
    localparam logic [7:0] A_CLO  = 8'h72;
    localparam logic [7:0] A_CHI  = 8'h73;
    localparam int         IMG    = 7600;

    always #2 clk = ~clk;

    cfgld_loader i_cfgld_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready_i    (ready_i),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .unlocked_o (unlocked_o),
        .done_o     (done_o)
    );

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic key(logic [7:0] a, logic [7:0] b, logic [7:0] c);
        wr(A_KEY, a); wr(A_KEY, b); wr(A_KEY, c);
    endtask

    task automatic count_now(output int c);
        logic [7:0] lo, hi;
        rd(A_CLO, lo);
        rd(A_CHI, hi);
        c = {hi, lo};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int         c;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        count_now(c);
        chk("R1 count", c, 0);
        rd(A_STAT, v);
        chk("R1 status", v, 8'h01);
        chk("R1 unlocked pin", unlocked_o, 0);
        chk("R1 done pin", done_o, 0);

        // R6 locked data writes ignored
        for (int i = 0; i < 5; i++) wr(A_DATA, 8'(i));
        count_now(c);
        chk("R6 locked count", c, 0);

        // R4 key while not ready
        ready_i = 1'b0;
        key(8'h51, 8'h52, 8'h53);
        ready_i = 1'b1;
        rd(A_STAT, v);
        chk("R4 not ready", v, 8'h01);
        ready_i = 1'b0; wr(A_KEY, 8'h51); ready_i = 1'b1;
        wr(A_KEY, 8'h52); wr(A_KEY, 8'h53);
        rd(A_STAT, v);
        chk("R4 ready dropped mid-key", v, 8'h01);

        // R3 aborts by read, foreign write, data write; idle gaps keep key
        wr(A_KEY, 8'h51); rd(A_CLO, v); wr(A_KEY, 8'h52); wr(A_KEY, 8'h53);
        rd(A_STAT, v);
        chk("R3 read abort", v, 8'h01);
        wr(A_KEY, 8'h51); wr(A_KEY, 8'h52); wr(8'h10, 8'h00); wr(A_KEY, 8'h53);
        rd(A_STAT, v);
        chk("R3 foreign write abort", v, 8'h01);
        wr(A_KEY, 8'h51); wr(A_DATA, 8'h00); wr(A_KEY, 8'h52); wr(A_KEY, 8'h53);
        rd(A_STAT, v);
        chk("R3 data write abort", v, 8'h01);

        // R5 sweeps of each key position over every wrong value
        for (int x = 0; x < 256; x++) begin
            if (x != 8'h51) begin
                key(8'(x), 8'h52, 8'h53);
                chk("R5 sweep step1", unlocked_o, 0);
            end
            if (x != 8'h52) begin
                key(8'h51, 8'(x), 8'h53);
                chk("R5 sweep step2", unlocked_o, 0);
            end
            if (x != 8'h53) begin
                key(8'h51, 8'h52, 8'(x));
                chk("R5 sweep step3", unlocked_o, 0);
            end
            rd(A_STAT, v);
        end

        // R5 repeated first value restarts; R2 idle cycles do not abort
        wr(A_KEY, 8'h51); wr(A_KEY, 8'h51);
        repeat (3) @(negedge clk);
        wr(A_KEY, 8'h52); wr(A_KEY, 8'h53);
        rd(A_STAT, v);
        chk("R5 R2 restart unlock", v, 8'h03);
        chk("R2 unlocked pin", unlocked_o, 1);

        // R6 R7 full image load, count compared after every byte
        for (int i = 1; i <= IMG; i++) begin
            wr(A_DATA, 8'(i));
            count_now(c);
            chk("R6 count step", c, i);
            if (i == IMG - 1) begin
                rd(A_STAT, v);
                chk("R7 open before last", v, 8'h03);
            end
        end
        rd(A_STAT, v);
        chk("R7 status done", v, 8'h05);
        rd(A_CLO, v);
        chk("R9 low byte at end", v, 8'hB0);
        rd(A_CHI, v);
        chk("R9 high byte at end", v, 8'h1D);
        chk("R9 high unused bits", int'(v[7:5]), 0);
        for (int i = 0; i < 3; i++) wr(A_DATA, 8'hFF);
        count_now(c);
        chk("R7 saturated", c, IMG);
        chk("R7 done pin", done_o, 1);

        // R8 new unlock clears count and done
        key(8'h51, 8'h52, 8'h53);
        rd(A_STAT, v);
        chk("R8 reopen status", v, 8'h03);
        count_now(c);
        chk("R8 count cleared", c, 0);
        wr(A_DATA, 8'h00);
        count_now(c);
        chk("R8 count after one", c, 1);

        // R9 unmapped address and no strobe
        rd(8'h00, v);
        chk("R9 unmapped", v, 0);
        rd(A_KEY, v);
        chk("R9 key reg write only", v, 0);
        @(negedge clk);
        bus_addr = A_STAT;
        #1 chk("R9 no strobe", bus_rdata, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule